// File: doc/BRIEF.md
# 4:2:0 Native-to-Stream Video Repacker

This block sits between a multi-pixel-per-clock native video source and a video stream sink. Each beat carries `PPC` pixel slots of three components each. For RGB, 4:4:4 and 4:2:2 input the beat is forwarded in the same cycle, with only the component width adjusted. For 4:2:0 input the block rebuilds the chroma so the stream side sees 4:2:2 with vertical subsampling. Chroma appears on one line of each line pair and is zero on the other.

In the native 4:2:0 layout, each slot carries luma in component 0 and one chroma sample in component 1. That chroma is Cb on the first line of a pair and Cr on the second. A one-line buffer keeps the Cb samples of the even-slot pixels from the first line. While the second line streams through, even slots take the stored Cb and odd slots keep their own Cr, which gives Cb/Cr interleaving in 4:2:2 order. The first line of each pair goes out as luma only.

A small line-tracking state machine follows the line parity and the beat position. Its states are `LN_IDLE` (after reset, treated as the first line of a pair), `LN_EVEN` and `LN_ODD`. Any accepted beat with start-of-frame puts its line in `LN_EVEN`. An accepted end-of-line beat moves `LN_EVEN` to `LN_ODD` and `LN_ODD` to `LN_EVEN`. The remapping path is built only when the parameter `REMAP_EN` is set. Without it, 4:2:0 beats are forwarded unchanged.

Top module: `yuv420_remap`

## Requirements
- R1: For `fmt` codes 0 (RGB), 1 (4:4:4) and 2 (4:2:2), every component of `tdata` equals the width-adjusted input component in the same slot and position, in the same cycle. Slot p, component c occupies bits `[(3p+c)*CW +: CW]` on the output and `[(3p+c)*IN_W +: IN_W]` on the input.
- R2: With `REMAP_EN` = 0, `fmt` code 3 (4:2:0) is forwarded like R1, with no chroma rework.
- R3: An input component narrower than `CW` appears MSB-aligned with zero low bits. A wider one keeps its top `CW` bits and drops the rest.
- R4: With remapping active and `fmt` = 3, a beat on the first line of a pair outputs component 0 = adjusted luma, and components 1 and 2 = 0 in every slot.
- R5: With remapping active and `fmt` = 3, a beat at column k on the second line of a pair outputs component 0 = luma. Component 1 of even slots is the component-1 sample of the same slot and column from the most recent first-of-pair 4:2:0 line. Component 1 of odd slots is the current beat's component 1. Component 2 is 0.
- R6: A beat with `in_sof` high always belongs to the first line of a pair. Each accepted `in_eol` beat flips the parity for the next line. Parity is tracked for every format.
- R7: `tvalid`, `tuser` and `tlast` equal `in_valid`, `in_sof` and `in_eol` in the same cycle.
- R8: `in_ready` follows `tready`. A beat presented while `tready` is low is not consumed: column, parity and buffer contents stay put, and the same beat is output correctly once `tready` rises.
- R9: `line_err` rises after an accepted line whose beat count differs from `line_beats` (end-of-line early or late) and stays high until reset. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Colour format: 0 RGB, 1 4:4:4, 2 4:2:2, 3 4:2:0 |
| line_beats | input | $clog2(MAX_BEATS+1) | Beats per active line (1..MAX_BEATS) |
| in_data | input | PPC*3*IN_W | Native pixel slots |
| in_valid | input | 1 | Native beat present |
| in_sof | input | 1 | Native beat is first of frame |
| in_eol | input | 1 | Native beat is last of line |
| in_ready | output | 1 | Native beat is taken this cycle when valid |
| tdata | output | PPC*3*CW | Stream pixel slots |
| tvalid | output | 1 | Stream beat valid |
| tready | input | 1 | Stream sink ready |
| tuser | output | 1 | Stream start of frame |
| tlast | output | 1 | Stream end of line |
| line_err | output | 1 | Sticky line-length mismatch |

## Verification
Two functions that can land in the same cycle are back-pressure and the chroma fetch on a second-of-pair line. A stall on such a beat must neither advance the buffer column nor corrupt the merge. The bench provokes this with a directed line where `tready` drops before every beat, plus random stalls on 4:2:0 lines. It judges each beat by comparing the held output during the stall and the accepted output against a bench-side chroma model. The second overlap is a start-of-frame arriving while parity sits on the second line. The bench sends two start-of-frame lines back to back and expects luma-only output on both.

// File: rtl/yuv_remap_pkg.sv
package yuv_remap_pkg;
    typedef enum logic [1:0] {
        FMT_RGB = 2'd0,
        FMT_444 = 2'd1,
        FMT_422 = 2'd2,
        FMT_420 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_EVEN = 2'd1,
        LN_ODD  = 2'd2
    } line_state_e;
endpackage

// File: rtl/comp_resize.sv
module comp_resize #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    generate
        if (IN_W >= OUT_W) begin : g_trunc
            assign dout = din[IN_W-1 -: OUT_W];
        end else begin : g_pad
            assign dout = {din, {(OUT_W-IN_W){1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/chroma_buf.sv
module chroma_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/line_ctrl.sv
module line_ctrl import yuv_remap_pkg::*; #(
    parameter int MAX_BEATS = 16,
    parameter int CNT_W     = 5,
    parameter int AW        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             sof,
    input  logic             eol,
    input  logic [CNT_W-1:0] line_beats,
    output logic             odd_line,
    output logic [AW-1:0]    col,
    output logic             line_err
);
    line_state_e    state_q, state_d, eff;
    logic [AW-1:0]  col_q, col_d;
    logic           err_q, err_d, at_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            col_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            err_q   <= err_d;
        end
    end

    // outputs for the current beat
    always_comb begin
        eff      = (sof || state_q == LN_IDLE) ? LN_EVEN : state_q;
        col      = sof ? '0 : col_q;
        odd_line = (eff == LN_ODD);
        at_last  = (CNT_W'(col) == line_beats - CNT_W'(1));
    end

    // next state
    always_comb begin
        state_d = state_q;
        col_d   = col_q;
        err_d   = err_q;
        if (acc) begin
            unique case (eff)
                LN_EVEN: state_d = eol ? LN_ODD  : LN_EVEN;
                LN_ODD:  state_d = eol ? LN_EVEN : LN_ODD;
                default: state_d = LN_EVEN;
            endcase
            if (eol)
                col_d = '0;
            else if (col != AW'(MAX_BEATS - 1))
                col_d = col + 1'b1;
            else
                col_d = col;
            if (eol != at_last) err_d = 1'b1;
        end
    end

    assign line_err = err_q;

    assert_sof_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sof && eol) |=> (state_q == LN_ODD))
        else $error("sof+eol beat did not leave parity on second line");

    assert_col_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eol) |=> (col_q == '0))
        else $error("column not restarted after end of line");

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(state_q) && $stable(col_q)))
        else $error("line tracking moved without an accepted beat");

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q)
        else $error("line error flag cleared without reset");
endmodule

// File: rtl/yuv420_remap.sv
module yuv420_remap import yuv_remap_pkg::*; #(
    parameter int PPC       = 4,
    parameter int CW        = 12,
    parameter int IN_W      = 10,
    parameter int MAX_BEATS = 16,
    parameter bit REMAP_EN  = 1'b1,
    localparam int CNT_W    = $clog2(MAX_BEATS + 1),
    localparam int AW       = $clog2(MAX_BEATS),
    localparam int OW       = PPC * 3 * CW,
    localparam int IW       = PPC * 3 * IN_W,
    localparam int BW       = (PPC / 2) * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt,
    input  logic [CNT_W-1:0] line_beats,
    input  logic [IW-1:0]    in_data,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    output logic             in_ready,
    output logic [OW-1:0]    tdata,
    output logic             tvalid,
    input  logic             tready,
    output logic             tuser,
    output logic             tlast,
    output logic             line_err
);
    logic          acc, odd_line, remap_on;
    logic [AW-1:0] col;
    logic [CW-1:0] res [PPC][3];
    logic [BW-1:0] buf_wr, buf_rd;

    assign in_ready = tready;
    assign tvalid   = in_valid;
    assign tuser    = in_sof;
    assign tlast    = in_eol;
    assign acc      = in_valid && tready;
    assign remap_on = REMAP_EN && (fmt_e'(fmt) == FMT_420);

    for (genvar p = 0; p < PPC; p++) begin : g_slot
        for (genvar c = 0; c < 3; c++) begin : g_comp
            comp_resize #(.IN_W(IN_W), .OUT_W(CW)) u_rs (
                .din  (in_data[(p*3+c)*IN_W +: IN_W]),
                .dout (res[p][c])
            );
        end
    end

    for (genvar k = 0; k < PPC / 2; k++) begin : g_bw
        assign buf_wr[k*CW +: CW] = res[2*k][1];
    end

    line_ctrl #(.MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W), .AW(AW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .sof        (in_sof),
        .eol        (in_eol),
        .line_beats (line_beats),
        .odd_line   (odd_line),
        .col        (col),
        .line_err   (line_err)
    );

    generate
        if (REMAP_EN) begin : g_remap
            chroma_buf #(.DEPTH(MAX_BEATS), .W(BW)) u_buf (
                .clk   (clk),
                .we    (acc && remap_on && !odd_line),
                .addr  (col),
                .wdata (buf_wr),
                .rdata (buf_rd)
            );
        end else begin : g_plain
            assign buf_rd = '0;
        end
    endgenerate

    always_comb begin
        tdata = '0;
        for (int p = 0; p < PPC; p++) begin
            if (!remap_on) begin
                for (int c = 0; c < 3; c++) tdata[(p*3+c)*CW +: CW] = res[p][c];
            end else begin
                tdata[(p*3)*CW +: CW] = res[p][0];
                if (!odd_line)
                    tdata[(p*3+1)*CW +: CW] = '0;
                else if (p % 2 == 0)
                    tdata[(p*3+1)*CW +: CW] = buf_rd[(p/2)*CW +: CW];
                else
                    tdata[(p*3+1)*CW +: CW] = res[p][1];
                tdata[(p*3+2)*CW +: CW] = '0;
            end
        end
    end

    function automatic logic chroma_clear(input logic [OW-1:0] d);
        for (int p = 0; p < PPC; p++)
            if (d[(p*3+1)*CW +: 2*CW] != '0) return 1'b0;
        return 1'b1;
    endfunction

    assert_first_line_luma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && remap_on && !odd_line) |-> chroma_clear(tdata))
        else $error("chroma present on first line of a 4:2:0 pair");
endmodule

// File: tb/test_yuv420_remap.sv
module test_yuv420_remap;
    localparam int PPC  = 4;
    localparam int CW   = 12;
    localparam int IN_W = 10;
    localparam int MAXB = 16;
    localparam int NB   = 4;
    localparam int OW   = PPC * 3 * CW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst_n, in_valid, sof, eol, tready;
    logic [1:0]             fmt;
    logic [4:0]             line_beats;
    logic [PPC*3*IN_W-1:0]  din;
    logic [PPC*3*16-1:0]    din16;
    logic                   in_ready, tvalid, tuser, tlast, line_err;
    logic [OW-1:0]          tdata, tdata_r;
    logic                   in_ready_r, tvalid_r, tuser_r, tlast_r, line_err_r;

    yuv420_remap #(.PPC(PPC), .CW(CW), .IN_W(IN_W), .MAX_BEATS(MAXB), .REMAP_EN(1'b1)) i_yuv420_remap (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .line_beats(line_beats), .in_data(din),
        .in_valid(in_valid), .in_sof(sof), .in_eol(eol), .in_ready(in_ready),
        .tdata(tdata), .tvalid(tvalid), .tready(tready), .tuser(tuser), .tlast(tlast),
        .line_err(line_err));

    yuv420_remap #(.PPC(PPC), .CW(CW), .IN_W(16), .MAX_BEATS(MAXB), .REMAP_EN(1'b0)) i_yuv420_remap_raw (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .line_beats(line_beats), .in_data(din16),
        .in_valid(in_valid), .in_sof(sof), .in_eol(eol), .in_ready(in_ready_r),
        .tdata(tdata_r), .tvalid(tvalid_r), .tready(tready), .tuser(tuser_r), .tlast(tlast_r),
        .line_err(line_err_r));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit            m_odd = 1'b0;
    int            m_col = 0;
    logic [CW-1:0] m_cb [MAXB][PPC];

    function automatic logic [CW-1:0] pad_c(input logic [IN_W-1:0] x);
        return {x, {(CW-IN_W){1'b0}}};
    endfunction

    function automatic logic [CW-1:0] trunc_c(input logic [15:0] x);
        return x[15 -: CW];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; sof = 1'b0; eol = 1'b0; tready = 1'b1;
        #1;
    endtask

    task automatic do_beat(input logic [1:0] f, input bit s, input bit e, input bit stall);
        logic [OW-1:0] exp_d, exp_r;
        bit   par;
        int   col;
        string tag;
        @(negedge clk);
        for (int p = 0; p < PPC; p++)
            for (int c = 0; c < 3; c++) begin
                din[(p*3+c)*IN_W +: IN_W] = IN_W'($urandom);
                din16[(p*3+c)*16 +: 16]   = 16'($urandom);
            end
        fmt = f; sof = s; eol = e; in_valid = 1'b1; tready = !stall;
        par = s ? 1'b0 : m_odd;
        col = s ? 0 : m_col;
        exp_d = '0; exp_r = '0;
        for (int p = 0; p < PPC; p++)
            for (int c = 0; c < 3; c++) begin
                exp_r[(p*3+c)*CW +: CW] = trunc_c(din16[(p*3+c)*16 +: 16]);
                if (f != 2'd3)
                    exp_d[(p*3+c)*CW +: CW] = pad_c(din[(p*3+c)*IN_W +: IN_W]);
                else if (c == 0)
                    exp_d[(p*3)*CW +: CW] = pad_c(din[(p*3)*IN_W +: IN_W]);
                else if (c == 1 && par)
                    exp_d[(p*3+1)*CW +: CW] = (p % 2 == 0) ? m_cb[col][p]
                                                            : pad_c(din[(p*3+1)*IN_W +: IN_W]);
            end
        tag = (f != 2'd3) ? "R1" : (par ? "R5" : "R4");
        if (stall) begin
            #1;
            chk(in_ready == 1'b0, "R8", "in_ready during stall", 256'(in_ready), 256'(0));
            chk(tdata == exp_d, "R8", "tdata held during stall", 256'(tdata), 256'(exp_d));
            @(negedge clk);
            tready = 1'b1;
        end
        #1;
        chk(tdata == exp_d, tag, "tdata", 256'(tdata), 256'(exp_d));
        chk(tvalid == 1'b1 && tuser == s && tlast == e, "R7", "valid/user/last",
            256'({tvalid, tuser, tlast}), 256'({1'b1, s, e}));
        chk(in_ready == 1'b1, "R8", "in_ready when sink ready", 256'(in_ready), 256'(1));
        chk(tdata_r == exp_r, "R2", "raw path (R3 truncation)", 256'(tdata_r), 256'(exp_r));
        if (f == 2'd3 && !par)
            for (int p = 0; p < PPC; p += 2) m_cb[col][p] = pad_c(din[(p*3+1)*IN_W +: IN_W]);
        if (e) begin
            m_col = 0;
            m_odd = !par;
        end else begin
            m_col = col + 1;
            m_odd = par;
        end
    endtask

    task automatic send_line(input logic [1:0] f, input bit s, input int stall_mode);
        for (int b = 0; b < NB; b++)
            do_beat(f, s && (b == 0), b == NB - 1,
                    stall_mode == 2 || (stall_mode == 1 && ($urandom % 3 == 0)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; sof = 1'b0; eol = 1'b0; tready = 1'b1;
        fmt = 2'd0; line_beats = 5'(NB); din = '0; din16 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(line_err == 1'b0, "R9", "line_err after reset", 256'(line_err), 256'(0));
        chk(tvalid == 1'b0, "R7", "tvalid after reset", 256'(tvalid), 256'(0));
        chk(in_ready == 1'b1, "R8", "in_ready after reset", 256'(in_ready), 256'(1));

        // 4:2:0 frame, including a line fully stalled beat by beat
        send_line(2'd3, 1'b1, 0);
        send_line(2'd3, 1'b0, 0);
        send_line(2'd3, 1'b0, 0);
        send_line(2'd3, 1'b0, 2);
        // pass-through formats (R1)
        send_line(2'd0, 1'b1, 0);
        send_line(2'd1, 1'b0, 1);
        send_line(2'd2, 1'b0, 0);
        // R6: start-of-frame while parity sits on the second line
        send_line(2'd3, 1'b1, 0);
        send_line(2'd3, 1'b1, 0);
        send_line(2'd3, 1'b0, 1);
        // random mix, mostly 4:2:0
        for (int i = 0; i < 24; i++) begin
            logic [1:0] f;
            f = ($urandom % 4 == 0) ? 2'($urandom % 3) : 2'd3;
            send_line(f, (i % 4 == 0), 1);
        end
        idle();
        chk(line_err == 1'b0, "R9", "no error on well-formed lines", 256'(line_err), 256'(0));

        // short line: end-of-line on beat 2 of 4
        do_beat(2'd3, 1'b1, 1'b0, 1'b0);
        do_beat(2'd3, 1'b0, 1'b1, 1'b0);
        idle();
        chk(line_err == 1'b1, "R9", "error after short line", 256'(line_err), 256'(1));
        send_line(2'd3, 1'b1, 0);
        idle();
        chk(line_err == 1'b1, "R9", "error stays set", 256'(line_err), 256'(1));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule